// File: doc/BRIEF.md
# CAN Controller Operating Mode Sequencer

This block decides which of three operating modes a CAN controller is in: sleep, initialization or normal. Software drives two request inputs, one asking for initialization and one asking for sleep. The block confirms each move with an acknowledge output. That output rises only after the mode has actually been taken. The controller is in normal mode whenever both acknowledges are low.

A move into normal mode is never immediate. The sequencer first waits for the bus to go idle. It counts consecutive recessive samples on the receive line, taking one sample per strobe from the bit-timing logic. During that wait, the acknowledge of the mode being left stays high. If software raises a request again while the wait is still running, the block drops straight back into the requested mode.

The sequencer also drives the enables for the transmit and receive paths, a control that forces the transmit pin recessive, and a pin pull-up enable. All of these are registered.

Top module: `can_mode_seq`

## Requirements
- R1: On a synchronous reset the block is in sleep mode. After reset, sleep_ack=1, init_ack=0, pullup_en=1, tx_en=0, rx_en=0 and tx_force_rec=1.
- R2: While init_req=1, the clock edge moves the block to initialization mode from any mode. From that edge, init_ack=1 and sleep_ack=0.
- R3: While sleep_req=1 and init_req=0, the clock edge moves the block to sleep mode from initialization, normal or bus synchronization. From that edge, sleep_ack=1 and init_ack=0.
- R4: When init_req and sleep_req are both 1, init_req wins and the block enters initialization mode.
- R5: pullup_en falls at the first edge that enters initialization, sleep or normal mode by a mode change. Once low, it stays low until reset.
- R6: init_ack and sleep_ack are never both 1. tx_en is 1 exactly when both acknowledges are 0, which is normal mode.
- R7: When both requests are 0 in sleep or initialization mode, the block starts bus synchronization and keeps the acknowledge of the mode it came from. That acknowledge falls, and normal mode begins, one clock after the edge that records the IDLE_BITS-th (default 11) consecutive recessive sample.
- R8: A dominant sample (rx_in=0) taken with sample_strobe=1 sets the recessive count back to zero. A full IDLE_BITS new recessive samples are then needed.
- R9: rx_in has no effect on cycles where sample_strobe=0. Only strobed samples are counted.
- R10: Raising a request again during synchronization returns the block to the requested mode. Normal mode is not entered on the way, so tx_en stays 0.
- R11: Outside normal mode, tx_force_rec=1, tx_en=0 and rx_en=0. In normal mode, tx_force_rec=0.
- R12: filter_init=1 forces rx_en to 0 from the next edge, in every mode including normal. When filter_init returns to 0 in normal mode, rx_en returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Software request for initialization mode |
| sleep_req | input | 1 | Software request for sleep mode |
| filter_init | input | 1 | Acceptance filter setup in progress; disables reception |
| sample_strobe | input | 1 | One-cycle pulse at each bit sample point |
| rx_in | input | 1 | Receive line level (1 = recessive) |
| init_ack | output | 1 | Initialization mode entered |
| sleep_ack | output | 1 | Sleep mode entered |
| tx_en | output | 1 | Transmit path enable |
| rx_en | output | 1 | Receive path enable |
| tx_force_rec | output | 1 | Hold transmit pin recessive |
| pullup_en | output | 1 | Transmit pin pull-up enable |

## Verification
The bench builds the block with the default IDLE_BITS of 11, so its counter is 4 bits wide. This lets the bench test the exact boundary: after ten recessive strobes the block must still be waiting, and the eleventh strobe releases it. The same width is enough to show a dominant strobe in the middle of the run throwing away ten counted bits. It is also enough to show that dominant levels between strobes are ignored. The vector table walks each request transition, including the case where both requests are set and a request raised again during synchronization.

// File: rtl/can_mode_pkg.sv
`timescale 1ns/1ps
package can_mode_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP  = 2'd0,
    MODE_INIT   = 2'd1,
    MODE_SYNC   = 2'd2,
    MODE_NORMAL = 2'd3
  } can_mode_e;
endpackage

// File: rtl/can_idle_counter.sv
`timescale 1ns/1ps
// Counts consecutive recessive samples taken at the sample-point strobe.
module can_idle_counter #(
  parameter int IDLE_BITS = 11,
  localparam int CNT_W = $clog2(IDLE_BITS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic strobe,
  input  logic rx,
  output logic done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (strobe) begin
      if (!rx)
        cnt_q <= '0;
      else if (cnt_q != CNT_W'(IDLE_BITS))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == CNT_W'(IDLE_BITS));

  AST_DOMINANT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (en && strobe && !rx) |=> (cnt_q == '0)); // R8

  AST_NO_STROBE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (en && !strobe) |=> $stable(cnt_q)); // R9

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(IDLE_BITS)); // R7
endmodule

// File: rtl/can_mode_fsm.sv
`timescale 1ns/1ps
// Mode state and next-mode decision.
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      init_req,
  input  logic      sleep_req,
  input  logic      idle_done,
  output can_mode_e mode_q,
  output can_mode_e mode_nxt,
  output logic      from_init_nxt,
  output logic      sync_active
);
  logic from_init_q;

  always_comb begin
    mode_nxt      = mode_q;
    from_init_nxt = from_init_q;
    if (init_req) begin
      mode_nxt = MODE_INIT;
    end else if (sleep_req) begin
      mode_nxt = MODE_SLEEP;
    end else begin
      unique case (mode_q)
        MODE_SLEEP: begin
          mode_nxt      = MODE_SYNC;
          from_init_nxt = 1'b0;
        end
        MODE_INIT: begin
          mode_nxt      = MODE_SYNC;
          from_init_nxt = 1'b1;
        end
        MODE_SYNC:   if (idle_done) mode_nxt = MODE_NORMAL;
        MODE_NORMAL: mode_nxt = MODE_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_SLEEP;
      from_init_q <= 1'b0;
    end else begin
      mode_q      <= mode_nxt;
      from_init_q <= from_init_nxt;
    end
  end

  assign sync_active = (mode_q == MODE_SYNC);

  AST_INIT_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    init_req |=> (mode_q == MODE_INIT)); // R4

  AST_NORMAL_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_q == MODE_NORMAL) |-> $past(idle_done)); // R7

  AST_NORMAL_NEVER_RESYNCS: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_NORMAL) |=> (mode_q != MODE_SYNC)); // R10
endmodule

// File: rtl/can_mode_outputs.sv
`timescale 1ns/1ps
// Registered decode of the next mode into acknowledge and pin controls.
module can_mode_outputs
  import can_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  can_mode_e mode_q,
  input  can_mode_e mode_nxt,
  input  logic      from_init_nxt,
  input  logic      filter_init,
  output logic      init_ack,
  output logic      sleep_ack,
  output logic      tx_en,
  output logic      rx_en,
  output logic      tx_force_rec,
  output logic      pullup_en
);
  logic nxt_normal;
  logic mode_entered;

  assign nxt_normal   = (mode_nxt == MODE_NORMAL);
  assign mode_entered = (mode_nxt != mode_q) && (mode_nxt != MODE_SYNC);

  always_ff @(posedge clk) begin
    if (rst) begin
      init_ack     <= 1'b0;
      sleep_ack    <= 1'b1;
      tx_en        <= 1'b0;
      rx_en        <= 1'b0;
      tx_force_rec <= 1'b1;
      pullup_en    <= 1'b1;
    end else begin
      init_ack     <= (mode_nxt == MODE_INIT) ||
                      ((mode_nxt == MODE_SYNC) && from_init_nxt);
      sleep_ack    <= (mode_nxt == MODE_SLEEP) ||
                      ((mode_nxt == MODE_SYNC) && !from_init_nxt);
      tx_en        <= nxt_normal;
      rx_en        <= nxt_normal && !filter_init;
      tx_force_rec <= !nxt_normal;
      if (mode_entered)
        pullup_en <= 1'b0;
    end
  end

  AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(init_ack && sleep_ack)); // R6

  AST_TX_EN_IN_NORMAL: assert property (@(posedge clk) disable iff (rst)
    tx_en == (!init_ack && !sleep_ack)); // R6

  AST_FORCE_REC_OFF_NORMAL: assert property (@(posedge clk) disable iff (rst)
    tx_force_rec != tx_en); // R11

  AST_RX_NEEDS_TX: assert property (@(posedge clk) disable iff (rst)
    rx_en |-> tx_en); // R11

  AST_FILTER_BLOCKS_RX: assert property (@(posedge clk) disable iff (rst)
    filter_init |=> !rx_en); // R12

  AST_PULLUP_STICKY: assert property (@(posedge clk) disable iff (rst)
    !pullup_en |=> !pullup_en); // R5
endmodule

// File: rtl/can_mode_seq.sv
`timescale 1ns/1ps
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic init_req,
  input  logic sleep_req,
  input  logic filter_init,
  input  logic sample_strobe,
  input  logic rx_in,
  output logic init_ack,
  output logic sleep_ack,
  output logic tx_en,
  output logic rx_en,
  output logic tx_force_rec,
  output logic pullup_en
);
  can_mode_e mode_q;
  can_mode_e mode_nxt;
  logic      from_init_nxt;
  logic      sync_active;
  logic      idle_done;

  can_idle_counter #(.IDLE_BITS(IDLE_BITS)) i_idle (
    .clk    (clk),
    .rst    (rst),
    .en     (sync_active),
    .strobe (sample_strobe),
    .rx     (rx_in),
    .done   (idle_done)
  );

  can_mode_fsm i_fsm (
    .clk           (clk),
    .rst           (rst),
    .init_req      (init_req),
    .sleep_req     (sleep_req),
    .idle_done     (idle_done),
    .mode_q        (mode_q),
    .mode_nxt      (mode_nxt),
    .from_init_nxt (from_init_nxt),
    .sync_active   (sync_active)
  );

  can_mode_outputs i_out (
    .clk           (clk),
    .rst           (rst),
    .mode_q        (mode_q),
    .mode_nxt      (mode_nxt),
    .from_init_nxt (from_init_nxt),
    .filter_init   (filter_init),
    .init_ack      (init_ack),
    .sleep_ack     (sleep_ack),
    .tx_en         (tx_en),
    .rx_en         (rx_en),
    .tx_force_rec  (tx_force_rec),
    .pullup_en     (pullup_en)
  );

  AST_SLEEP_REQ_TAKES: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && !init_req) |=> (sleep_ack && !init_ack)); // R3

  AST_INIT_REQ_TAKES: assert property (@(posedge clk) disable iff (rst)
    init_req |=> (init_ack && !sleep_ack)); // R2
endmodule

// File: tb/test_can_mode_seq.sv
`timescale 1ns/1ps
module test_can_mode_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_req = 1'b0, sleep_req = 1'b1, filter_init = 1'b0;
  logic sample_strobe = 1'b0, rx_in = 1'b1;
  logic init_ack, sleep_ack, tx_en, rx_en, tx_force_rec, pullup_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  can_mode_seq i_can_mode_seq (
    .clk(clk), .rst(rst), .init_req(init_req), .sleep_req(sleep_req),
    .filter_init(filter_init), .sample_strobe(sample_strobe), .rx_in(rx_in),
    .init_ack(init_ack), .sleep_ack(sleep_ack), .tx_en(tx_en), .rx_en(rx_en),
    .tx_force_rec(tx_force_rec), .pullup_en(pullup_en)
  );

  // {init_req, sleep_req, filter_init, strobe, rx} , {init_ack, sleep_ack, tx_en, rx_en, force_rec}
  localparam logic [9:0] VEC [26] = '{
    10'b01000_01001, // stay asleep (R3)
    10'b11000_10001, // both set: init wins (R4)
    10'b10000_10001, // hold init (R2, R11)
    10'b01000_01001, // init -> sleep (R3)
    10'b10000_10001, // sleep -> init (R2)
    10'b00000_10001, // start sync from init, ack held (R7)
    10'b00011_10001, 10'b00011_10001, 10'b00011_10001, 10'b00011_10001,
    10'b00011_10001, 10'b00011_10001, 10'b00011_10001, 10'b00011_10001,
    10'b00011_10001, 10'b00011_10001, 10'b00011_10001, // 11 recessive strobes (R7)
    10'b00000_00110, // normal mode (R6, R7, R11)
    10'b00100_00100, // filter init blocks rx (R12)
    10'b00000_00110, // rx back (R12)
    10'b01000_01001, // normal -> sleep (R3)
    10'b00000_01001, // sync from sleep (R7)
    10'b00011_01001, // one recessive (R7)
    10'b00010_01001, // dominant clears (R8)
    10'b00001_01001, // no strobe (R9)
    10'b01000_01001  // request again during sync: back to sleep (R10)
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic ir, input logic sr, input logic fi,
                      input logic stb, input logic rx);
    init_req = ir; sleep_req = sr; filter_init = fi; sample_strobe = stb; rx_in = rx;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 reset acks/enables",
          {2'b0, init_ack, sleep_ack, tx_en, rx_en, tx_force_rec, pullup_en},
          8'b00010011);
    rst = 1'b0;
    step(0, 1, 0, 0, 1);
    step(0, 1, 0, 0, 1);
    check("R5 pullup kept while reset sleep held", {7'b0, pullup_en}, 8'd1);

    for (int i = 0; i < 26; i++) begin
      step(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
      check($sformatf("R2/R3/R4/R6/R7/R8/R10/R11/R12 row %0d", i),
            {3'b0, init_ack, sleep_ack, tx_en, rx_en, tx_force_rec},
            {3'b0, VEC[i][4:0]});
    end

    // R5: pullup dropped after first mode change
    check("R5 pullup low after mode change", {7'b0, pullup_en}, 8'd0);

    // R8: dominant mid-run restarts the count
    step(0, 0, 0, 0, 1);
    check("R7 sync from sleep keeps sleep_ack", {6'b0, init_ack, sleep_ack}, 8'b01);
    for (int k = 0; k < 10; k++) step(0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 0);
    for (int k = 0; k < 10; k++) step(0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1);
    check("R8 ten after dominant not enough", {6'b0, sleep_ack, tx_en}, 8'b10);
    step(0, 0, 0, 1, 1);
    check("R7 eleventh edge still acked", {6'b0, sleep_ack, tx_en}, 8'b10);
    step(0, 0, 0, 0, 1);
    check("R7 normal one clock after eleventh", {6'b0, sleep_ack, tx_en}, 8'b01);
    check("R5 pullup stays low", {7'b0, pullup_en}, 8'd0);

    // R9: dominant levels between strobes ignored
    step(1, 0, 0, 0, 1);
    check("R2 normal -> init", {6'b0, init_ack, sleep_ack}, 8'b10);
    step(0, 0, 0, 0, 1);
    for (int k = 0; k < 5; k++) step(0, 0, 0, 1, 1);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0);
    for (int k = 0; k < 6; k++) step(0, 0, 0, 1, 1);
    check("R9 still syncing at eleventh edge", {6'b0, init_ack, tx_en}, 8'b10);
    step(0, 0, 0, 0, 1);
    check("R9 unstrobed dominant ignored", {6'b0, init_ack, tx_en}, 8'b01);
    check("R11 normal releases force", {7'b0, tx_force_rec}, 8'd0);

    // R12: filter init in non-normal mode
    step(1, 0, 1, 0, 1);
    check("R12 filter in init keeps rx off", {6'b0, rx_en, tx_force_rec}, 8'b01);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule